// File: doc/BRIEF.md
# Configuration Container Section Parser

This block reads a configuration file one byte at a time on a valid/ready input stream. It first checks that the stream opens with a fixed 13-byte signature. It then walks a chain of sections. Each section is a one-character type, a big-endian length and a payload of that many bytes.

Only the payload of the bitstream section (type `'e'`) passes to the byte output stream. The last byte of that payload is marked with a last flag. The length of that section is reported on its own output. Text sections are skipped by their length and are never stored.

A malformed or cut-short stream is reported with a fault code. After a fault, or after the bitstream payload has been delivered, the parser stops accepting input until it is reset.

Top module: `bitfile_section_parser`

## Requirements
- R1: The first 13 accepted bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. On the first byte that differs, `fault` goes high with `fault_code` = 1 in the next cycle.
- R2: A section type byte must lie in 0x61..0x65 (`'a'`..`'e'`). Any other value raises `fault` with `fault_code` = 2.
- R3: Types 0x61..0x64 carry a 2-byte length, high byte first. Their payload bytes are consumed with `in_ready` held high and never appear on the output. A zero length goes straight to the next type byte.
- R4: A section of type 0x61..0x64 whose length is above 255 raises `fault` with `fault_code` = 3. A length of exactly 255 is accepted.
- R5: Type 0x65 carries a 4-byte length, high byte first. From the cycle after its final length byte, `sect_len` holds that value and `sect_len_valid` is high. Both stay that way until reset.
- R6: During the 0x65 payload, each input byte appears unchanged and in order on `out_data`. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so a stalled output holds off the input.
- R7: `out_last` is high on the final 0x65 payload byte. After that byte is transferred, `done` is high and `in_ready` is low.
- R8: If a byte is accepted with `in_last` high before the 0x65 section is complete, `fault` goes high with `fault_code` = 4. Faults of codes 1 to 3 on that same byte take priority.
- R9: A 0x65 section of length zero sets `done` with no output transfer.
- R10: `done` and `fault` are never high together. Each is sticky until reset, `fault_code` does not change while `fault` is high, and `in_ready` is low while either is high.
- R11: After reset, `in_ready` = 1, `out_valid` = 0, `done` = 0, `fault` = 0 and `sect_len_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the input stream |
| in_ready | output | 1 | Parser accepts the input byte |
| out_valid | output | 1 | Output payload byte valid |
| out_data | output | 8 | Output payload byte |
| out_last | output | 1 | Final byte of the bitstream payload |
| out_ready | input | 1 | Downstream accepts the output byte |
| sect_len | output | 32 | Length of the bitstream section |
| sect_len_valid | output | 1 | `sect_len` holds a decoded value |
| done | output | 1 | Bitstream payload fully delivered |
| fault | output | 1 | Parsing stopped on an error |
| fault_code | output | 3 | 1 signature, 2 type, 3 length, 4 truncated |

## Verification
The bench checks that a 255-byte short section is accepted while a 256-byte one is rejected. An off-by-one in the length comparison would flip one of these two outcomes.

It also tests the following cases:
- **Zero-length sections.** These must be hopped over without a bubble, and an empty bitstream must finish without an output. A design that loads the counter with zero would hang or underflow.
- **Random output backpressure over a 258-byte payload.** A passthrough that drops the stall would lose or duplicate bytes in the scoreboard.
- **An input cut short in a skipped section and in the bitstream section.** A design that ignores the end marker would wait forever.
- **A corrupted signature byte in the middle.** A design that only compares the ends would miss it.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int SIG_BYTES = 13;
  localparam int SIG_IDX_W = $clog2(SIG_BYTES);

  typedef enum logic [2:0] {
    ST_SIG, ST_TYPE, ST_LEN, ST_SKIP, ST_DATA, ST_DONE, ST_FAIL
  } pstate_t;

  typedef enum logic [2:0] {
    FAULT_NONE  = 3'd0,
    FAULT_SIG   = 3'd1,
    FAULT_TYPE  = 3'd2,
    FAULT_LEN   = 3'd3,
    FAULT_TRUNC = 3'd4
  } fault_t;

  localparam logic [7:0] TYPE_LOW  = 8'h61;
  localparam logic [7:0] TYPE_HIGH = 8'h65;
  localparam logic [7:0] TYPE_BITS = 8'h65;

  // Expected signature byte at position idx
  function automatic logic [7:0] sig_byte(input logic [SIG_IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      4'd1:                   b = 8'h09;
      4'd2, 4'd4, 4'd6, 4'd8: b = 8'h0F;
      4'd3, 4'd5, 4'd7, 4'd9: b = 8'hF0;
      4'd12:                  b = 8'h01;
      default:                b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic type_legal(input logic [7:0] b);
    return (b >= TYPE_LOW) && (b <= TYPE_HIGH);
  endfunction

  function automatic logic type_is_bits(input logic [7:0] b);
    return b == TYPE_BITS;
  endfunction
endpackage

// File: rtl/bsp_sig_check.sv
module bsp_sig_check
  import bsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] data,
  output logic       match,
  output logic       at_end
);
  logic [SIG_IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else if (step && !at_end) idx <= idx + 1'b1;
  end

  assign match  = (data == sig_byte(idx));
  assign at_end = (idx == SIG_IDX_W'(SIG_BYTES - 1));
endmodule

// File: rtl/bsp_len_collect.sv
module bsp_len_collect #(
  parameter int LEN_W       = 32,
  parameter int DATA_W      = 8,
  parameter int SHORT_BYTES = 2,
  parameter int LONG_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_long,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic [LEN_W-1:0]  value_next,
  output logic              final_byte,
  output logic              is_long
);
  localparam int CNT_W = $clog2(LONG_BYTES + 1);

  logic [LEN_W-1:0] acc;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      cnt     <= '0;
      is_long <= 1'b0;
    end else if (start) begin
      acc     <= '0;
      cnt     <= '0;
      is_long <= start_long;
    end else if (shift) begin
      acc <= value_next;
      cnt <= cnt + 1'b1;
    end
  end

  // Big-endian accumulation: earlier bytes move up
  assign value_next = {acc[LEN_W-DATA_W-1:0], data};
  assign final_byte = is_long ? (cnt == CNT_W'(LONG_BYTES - 1))
                              : (cnt == CNT_W'(SHORT_BYTES - 1));
endmodule

// File: rtl/bsp_down_count.sv
module bsp_down_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_one
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) remain <= '0;
    else if (load) remain <= load_val;
    else if (dec && remain != '0) remain <= remain - 1'b1;
  end

  assign is_one = (remain == W'(1));
endmodule

// File: rtl/bitfile_section_parser.sv
module bitfile_section_parser
  import bsp_pkg::*;
#(
  parameter int LEN_W       = 32,
  parameter int DATA_W      = 8,
  parameter int SHORT_BYTES = 2,
  parameter int LONG_BYTES  = 4,
  parameter int SHORT_MAX   = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic [LEN_W-1:0]  sect_len,
  output logic              sect_len_valid,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_code
);
  pstate_t st, st_n;
  fault_t  fault_q, fault_n;

  // Named internal events
  logic ev_accept, ev_sig_fail, ev_type_fail, ev_len_fail, ev_trunc;
  logic ev_len_done, ev_bits_len, ev_finish;

  logic sig_match, sig_at_end;
  logic [LEN_W-1:0] len_next;
  logic len_final, len_long;
  logic rem_is_one;

  assign ev_accept   = in_valid && in_ready;
  assign ev_len_done = ev_accept && (st == ST_LEN) && len_final;
  assign ev_bits_len = ev_len_done && len_long;

  bsp_sig_check u_sig (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (ev_accept && st == ST_SIG),
    .data   (in_data),
    .match  (sig_match),
    .at_end (sig_at_end)
  );

  bsp_len_collect #(
    .LEN_W(LEN_W), .DATA_W(DATA_W),
    .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
  ) u_len (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_accept && st == ST_TYPE),
    .start_long (type_is_bits(in_data)),
    .shift      (ev_accept && st == ST_LEN),
    .data       (in_data),
    .value_next (len_next),
    .final_byte (len_final),
    .is_long    (len_long)
  );

  bsp_down_count #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_len_done),
    .load_val (len_next),
    .dec      (ev_accept && (st == ST_SKIP || st == ST_DATA)),
    .is_one   (rem_is_one)
  );

  always_comb begin
    st_n         = st;
    fault_n      = fault_q;
    ev_sig_fail  = 1'b0;
    ev_type_fail = 1'b0;
    ev_len_fail  = 1'b0;
    ev_trunc     = 1'b0;
    ev_finish    = 1'b0;
    if (ev_accept) begin
      unique case (st)
        ST_SIG: begin
          if (!sig_match)     ev_sig_fail = 1'b1;
          else if (in_last)   ev_trunc    = 1'b1;
          else if (sig_at_end) st_n       = ST_TYPE;
        end
        ST_TYPE: begin
          if (!type_legal(in_data)) ev_type_fail = 1'b1;
          else if (in_last)         ev_trunc     = 1'b1;
          else                      st_n         = ST_LEN;
        end
        ST_LEN: begin
          if (len_final) begin
            if (!len_long && len_next > LEN_W'(SHORT_MAX)) ev_len_fail = 1'b1;
            else if (len_long && len_next == '0)           ev_finish   = 1'b1;
            else if (in_last)                              ev_trunc    = 1'b1;
            else if (len_next == '0)                       st_n        = ST_TYPE;
            else st_n = len_long ? ST_DATA : ST_SKIP;
          end else if (in_last) begin
            ev_trunc = 1'b1;
          end
        end
        ST_SKIP: begin
          if (in_last)         ev_trunc = 1'b1;
          else if (rem_is_one) st_n     = ST_TYPE;
        end
        ST_DATA: begin
          if (rem_is_one)   ev_finish = 1'b1;
          else if (in_last) ev_trunc  = 1'b1;
        end
        default: ;
      endcase
    end
    if (ev_finish) st_n = ST_DONE;
    if (ev_sig_fail)  begin st_n = ST_FAIL; fault_n = FAULT_SIG;   end
    if (ev_type_fail) begin st_n = ST_FAIL; fault_n = FAULT_TYPE;  end
    if (ev_len_fail)  begin st_n = ST_FAIL; fault_n = FAULT_LEN;   end
    if (ev_trunc)     begin st_n = ST_FAIL; fault_n = FAULT_TRUNC; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_SIG;
      fault_q        <= FAULT_NONE;
      sect_len       <= '0;
      sect_len_valid <= 1'b0;
    end else begin
      st      <= st_n;
      fault_q <= fault_n;
      if (ev_bits_len) begin
        sect_len       <= len_next;
        sect_len_valid <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_DATA:          in_ready = out_ready;
      ST_DONE, ST_FAIL: in_ready = 1'b0;
      default:          in_ready = 1'b1;
    endcase
  end

  assign out_valid  = (st == ST_DATA) && in_valid;
  assign out_data   = in_data;
  assign out_last   = (st == ST_DATA) && rem_is_one;
  assign done       = (st == ST_DONE);
  assign fault      = (st == ST_FAIL);
  assign fault_code = fault_q;
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_last,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic       sect_len_valid,
  input logic       done,
  input logic       fault,
  input logic [2:0] fault_code,
  input logic       ev_accept
);
  assert_stall_holds_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_out_needs_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);

  assert_len_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sect_len_valid);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> done);

  assert_trunc_needs_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault) && fault_code == 3'd4) |-> $past(ev_accept && in_last));

  assert_terminal_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !in_ready);

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (fault && $stable(fault_code)));

  assert_exclusive_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
endmodule

bind bitfile_section_parser bsp_checker u_bsp_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_last        (in_last),
  .in_ready       (in_ready),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_last       (out_last),
  .sect_len_valid (sect_len_valid),
  .done           (done),
  .fault          (fault),
  .fault_code     (fault_code),
  .ev_accept      (ev_accept)
);

// File: tb/test_bitfile_section_parser.sv
`timescale 1ns/100ps
module test_bitfile_section_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b1;
  logic [31:0] sect_len;
  logic        sect_len_valid;
  logic        done;
  logic        fault;
  logic [2:0]  fault_code;

  int checks = 0;
  int fails = 0;
  logic [8:0] sb_q[$];
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] sig_ref [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                               8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

  always #2.5 clk = ~clk;

  bitfile_section_parser i_bitfile_section_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .sect_len(sect_len), .sect_len_valid(sect_len_valid), .done(done),
    .fault(fault), .fault_code(fault_code)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Output ready pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // Monitor: pops expected bytes as transfers happen
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected output byte", {out_last, out_data}, 0);
      end else begin
        logic [8:0] e;
        e = sb_q.pop_front();
        check({out_last, out_data} == e, "R6/R7 payload byte", {out_last, out_data}, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; bp_en = 1'b0;
    sb_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [7:0] b, input bit lst, input bit nowait);
    bit waited = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = lst;
    forever begin
      #1;
      if (in_ready) break;
      waited = 1'b1;
      @(negedge clk);
    end
    @(posedge clk);
    #1 in_valid = 1'b0; in_last = 1'b0;
    if (nowait) check(!waited, "R3 in_ready high while skipping", waited, 0);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic send_header();
    for (int i = 0; i < 13; i++) push(sig_ref[i], 1'b0, 1'b0);
  endtask

  task automatic send_short(input logic [7:0] t, input int len, input int stop_at);
    push(t, 1'b0, 1'b0);
    push(8'(len >> 8), 1'b0, 1'b0);
    push(8'(len), 1'b0, 1'b0);
    for (int i = 0; i < len && i < stop_at; i++)
      push(8'(i + 8'h40), (i == stop_at - 1), 1'b1);
  endtask

  task automatic send_bits_len(input int len, input bit lst);
    push(8'h65, 1'b0, 1'b0);
    push(8'(len >> 24), 1'b0, 1'b0);
    push(8'(len >> 16), 1'b0, 1'b0);
    push(8'(len >> 8), 1'b0, 1'b0);
    push(8'(len), lst, 1'b0);
  endtask

  task automatic send_bits_payload(input int len, input int stop_at);
    for (int i = 0; i < len && i < stop_at; i++) begin
      logic [7:0] d;
      d = 8'(i * 7 + 3);
      sb_q.push_back({(i == len - 1), d});
      push(d, (i == len - 1) || (i == stop_at - 1), 1'b0);
    end
  endtask

  task automatic expect_fault(input logic [2:0] code, input string req);
    settle();
    check(fault == 1'b1, req, fault, 1);
    check(fault_code == code, req, fault_code, code);
    check(in_ready == 1'b0 && done == 1'b0, "R10 halted after fault", in_ready, 0);
  endtask

  initial begin
    do_reset();
    settle();
    // R11 reset state
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    check(done == 1'b0 && fault == 1'b0, "R11 done/fault", {done, fault}, 0);
    check(sect_len_valid == 1'b0, "R11 sect_len_valid", sect_len_valid, 0);

    // Good stream with short, empty and 255-byte sections (R3, R4, R5, R6, R7)
    send_header();
    send_short(8'h61, 3, 3 + 1000);
    send_short(8'h62, 0, 1000);
    send_short(8'h64, 255, 1000);
    check(fault == 1'b0, "R4 length 255 accepted", fault, 0);
    send_bits_len(5, 1'b0);
    settle();
    check(sect_len_valid && sect_len == 32'd5, "R5 length reported", sect_len, 5);
    send_bits_payload(5, 1000);
    settle();
    check(done == 1'b1 && fault == 1'b0, "R7 done after last", done, 1);
    check(in_ready == 1'b0, "R7 in_ready low when done", in_ready, 0);
    check(sb_q.size() == 0, "R6 all payload delivered", sb_q.size(), 0);

    // Signature corrupted at byte 4 (R1)
    do_reset();
    for (int i = 0; i < 4; i++) push(sig_ref[i], 1'b0, 1'b0);
    push(8'h0E, 1'b0, 1'b0);
    expect_fault(3'd1, "R1 signature mismatch");

    // Bad types above and below range (R2)
    do_reset();
    send_header();
    push(8'h66, 1'b0, 1'b0);
    expect_fault(3'd2, "R2 type 0x66 rejected");
    do_reset();
    send_header();
    push(8'h60, 1'b0, 1'b0);
    expect_fault(3'd2, "R2 type 0x60 rejected");

    // Short length of 256 (R4)
    do_reset();
    send_header();
    push(8'h63, 1'b0, 1'b0);
    push(8'h01, 1'b0, 1'b0);
    push(8'h00, 1'b0, 1'b0);
    expect_fault(3'd3, "R4 length 256 rejected");

    // Long payload with random backpressure (R5, R6)
    do_reset();
    bp_en = 1'b1;
    send_header();
    send_bits_len(258, 1'b0);
    settle();
    check(sect_len_valid && sect_len == 32'd258, "R5 four-byte length", sect_len, 258);
    send_bits_payload(258, 1000);
    settle();
    bp_en = 1'b0;
    check(done == 1'b1, "R7 done after backpressured payload", done, 1);
    check(sb_q.size() == 0, "R6 backpressured payload complete", sb_q.size(), 0);

    // Truncated inside a skipped section (R8)
    do_reset();
    send_header();
    send_short(8'h61, 4, 2);
    expect_fault(3'd4, "R8 truncated in skip");

    // Truncated inside bitstream payload (R8)
    do_reset();
    send_header();
    send_bits_len(6, 1'b0);
    send_bits_payload(6, 3);
    expect_fault(3'd4, "R8 truncated in payload");
    check(sb_q.size() == 0, "R8 partial payload forwarded", sb_q.size(), 0);

    // Empty bitstream section (R9)
    do_reset();
    send_header();
    send_bits_len(0, 1'b1);
    repeat (3) settle();
    check(done == 1'b1 && fault == 1'b0, "R9 empty section done", done, 1);
    check(sect_len_valid && sect_len == 32'd0, "R9 zero length reported", sect_len, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule